// File: doc/BRIEF.md
# Looping Sample Address Generator

This block produces the memory fetch address of one audio channel, sample by sample. Software sets four registers: a byte base address, a limit word, a position and a control word. The limit word holds the index of the last frame in the buffer and a fixed-point rate step. The position holds the current frame index and a 12-bit fraction. The control word sets the sample format and whether the buffer loops.

On every sample tick that arrives while `run` is high, the position advances by the step. A step of 4096 (1.0) is one frame per tick, which suits a channel running at the 48 kHz engine rate. Other rates use a step of rate × 4096 / 48000; for example, 44.1 kHz gives 3763. The fetch address is the base plus the frame index times the frame size. The frame size is 1, 2 or 4 bytes and follows the stereo and 16-bit control bits.

When an advance would carry the index past the last frame, the block raises `end_pulse` for one cycle. With looping enabled, the index then restarts at 0 and the fraction is kept. With looping disabled, the channel freezes until software writes the position or control register. Memory fetch and mixing happen outside this block.

Top module: `loop_addr_gen`

## Requirements
- R1: After reset, all registers are zero, `fetch_addr` is 0, `pos_rd` is 0 and `end_pulse` is low.
- R2: Register select 1 (limit) holds the last frame index in bits 31:16 and the step in bits 15:0. The step has 12 fractional bits. Each accepted advance adds the step to the 28-bit value {index, fraction}.
- R3: The position changes only at a clock edge where `tick` and `run` are both high, or where software writes the position. Other cycles leave `pos_rd` unchanged.
- R4: `fetch_addr` equals base (select 0) + index × frame bytes. Frame bytes are 1 for 8-bit mono, 2 for 8-bit stereo or 16-bit mono, and 4 for 16-bit stereo. Control (select 3) bit 14 selects stereo and bit 13 selects 16-bit samples; bit 15 is a signedness flag that does not affect addressing.
- R5: If an advance would produce an index greater than the last frame index, `end_pulse` is high for exactly the cycle after that edge. No other advance produces a pulse.
- R6: With control bit 12 (loop) set, an overflowing advance sets the index to 0 and keeps the fractional part of the sum.
- R7: With loop clear, an overflowing advance leaves the position unchanged and freezes the channel. Later ticks then cause neither an advance nor a pulse, until a write to the position or control register releases the freeze.
- R8: A write to select 2 (position) loads the index from bits 31:16 and the fraction from bits 11:0, so writing 0 clears both. `pos_rd` returns the index in bits 31:16, zeros in bits 15:12 and the fraction in bits 11:0.
- R9: In a cycle with any register write, no advance happens; the write takes effect alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 base, 1 limit, 2 position, 3 control |
| wr_data | input | 32 | Register write data |
| tick | input | 1 | Output sample tick |
| run | input | 1 | Channel running |
| fetch_addr | output | 32 | Byte address of the current frame |
| pos_rd | output | 32 | Current position: index, zero pad, fraction |
| end_pulse | output | 1 | One-cycle end-of-buffer pulse |

## Verification
A wrong fraction is invisible in `fetch_addr` at first. It does show in the low bits of `pos_rd` one cycle after the faulty advance, and it later moves a frame boundary by one tick. A wrong comparison against the last frame shows up as a missing or extra `end_pulse`, together with an index that either exceeds the last frame or returns to 0 early, within one tick of the buffer end. A stuck freeze shows up as `pos_rd` holding still under ticks after a release write, and a wrong frame size shows in `fetch_addr` as soon as the index is non-zero.

// File: rtl/agen_pkg.sv
package agen_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_POS   = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  localparam int CTRL_STEREO_BIT = 14;
  localparam int CTRL_WIDE_BIT   = 13;
  localparam int CTRL_LOOP_BIT   = 12;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] last;
    logic [15:0] step;
    logic        stereo;
    logic        wide;
    logic        loop_en;
  } chan_cfg_t;

  // log2 of the bytes per frame: mono 8-bit 0, one doubling 1, both 2
  function automatic logic [1:0] frame_shift(input logic stereo, input logic wide);
    frame_shift = {1'b0, stereo} + {1'b0, wide};
  endfunction

endpackage

// File: rtl/agen_cfg_regs.sv
module agen_cfg_regs
  import agen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output chan_cfg_t         cfg,
  output logic              pos_wr,
  output logic              ctrl_wr
);

  assign pos_wr  = wr_en && (wr_sel == SEL_POS);
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_BASE:  cfg.base <= wr_data;
        SEL_LIMIT: begin
          cfg.last <= wr_data[31:16];
          cfg.step <= wr_data[15:0];
        end
        SEL_CTRL: begin
          cfg.stereo  <= wr_data[CTRL_STEREO_BIT];
          cfg.wide    <= wr_data[CTRL_WIDE_BIT];
          cfg.loop_en <= wr_data[CTRL_LOOP_BIT];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/agen_phase_acc.sv
module agen_phase_acc #(
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 12,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_req,
  input  logic              any_wr,
  input  logic              pos_wr,
  input  logic              ctrl_wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [FRAC_W-1:0] wr_frac,
  input  logic [IDX_W-1:0]  last,
  input  logic [STEP_W-1:0] step,
  input  logic              loop_en,
  output logic [IDX_W-1:0]  idx,
  output logic [FRAC_W-1:0] frac,
  output logic              end_pulse,
  output logic              go,
  output logic              ovf,
  output logic              halt_q
);

  localparam int SUM_W = IDX_W + FRAC_W + 1;

  logic [SUM_W-1:0] sum;
  logic [IDX_W:0]   next_idx;

  assign sum      = {1'b0, idx, frac} + SUM_W'(step);
  assign next_idx = sum[SUM_W-1:FRAC_W];
  assign ovf      = next_idx > {1'b0, last};
  assign go       = adv_req && !halt_q && !any_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      frac      <= '0;
      halt_q    <= 1'b0;
      end_pulse <= 1'b0;
    end else begin
      end_pulse <= go && ovf;
      if (pos_wr) begin
        idx    <= wr_idx;
        frac   <= wr_frac;
        halt_q <= 1'b0;
      end else if (ctrl_wr) begin
        halt_q <= 1'b0;
      end else if (go) begin
        if (ovf) begin
          if (loop_en) begin
            idx  <= '0;
            frac <= sum[FRAC_W-1:0];
          end else begin
            halt_q <= 1'b1;
          end
        end else begin
          idx  <= next_idx[IDX_W-1:0];
          frac <= sum[FRAC_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/agen_addr_calc.sv
module agen_addr_calc
  import agen_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              stereo,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr
);

  logic [1:0] shamt;

  assign shamt = frame_shift(stereo, wide);
  assign addr  = base + (ADDR_W'(idx) << shamt);

endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen
  import agen_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 12,
  parameter int STEP_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        tick,
  input  logic        run,
  output logic [31:0] fetch_addr,
  output logic [31:0] pos_rd,
  output logic        end_pulse
);

  localparam int PAD_W = DATA_W - IDX_W - FRAC_W;

  chan_cfg_t         cfg;
  logic              pos_wr, ctrl_wr;
  logic [IDX_W-1:0]  idx;
  logic [FRAC_W-1:0] frac;
  logic              adv_go, adv_ovf, halt_q;
  logic              wrap_evt;

  agen_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cfg     (cfg),
    .pos_wr  (pos_wr),
    .ctrl_wr (ctrl_wr)
  );

  agen_phase_acc #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_req   (tick && run),
    .any_wr    (wr_en),
    .pos_wr    (pos_wr),
    .ctrl_wr   (ctrl_wr),
    .wr_idx    (wr_data[DATA_W-1 -: IDX_W]),
    .wr_frac   (wr_data[FRAC_W-1:0]),
    .last      (cfg.last[IDX_W-1:0]),
    .step      (cfg.step[STEP_W-1:0]),
    .loop_en   (cfg.loop_en),
    .idx       (idx),
    .frac      (frac),
    .end_pulse (end_pulse),
    .go        (adv_go),
    .ovf       (adv_ovf),
    .halt_q    (halt_q)
  );

  agen_addr_calc #(.IDX_W(IDX_W), .ADDR_W(DATA_W)) u_addr (
    .base   (cfg.base),
    .idx    (idx),
    .stereo (cfg.stereo),
    .wide   (cfg.wide),
    .addr   (fetch_addr)
  );

  assign pos_rd   = {idx, {PAD_W{1'b0}}, frac};
  assign wrap_evt = adv_go && adv_ovf && cfg.loop_en;

endmodule

// File: rtl/loop_addr_gen_chk.sv
module loop_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        tick,
  input logic        run,
  input logic [31:0] pos_rd,
  input logic        end_pulse,
  input logic        adv_go,
  input logic        adv_ovf,
  input logic        wrap_evt,
  input logic        halt_q
);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run) && !wr_en) |=> $stable(pos_rd));

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> $past(tick && run && !wr_en));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (pos_rd[31:16] == 16'd0));

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en) |=> ($stable(pos_rd) && !end_pulse));

  // R2
  forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_go && !adv_ovf) |=> (pos_rd >= $past(pos_rd)));

endmodule

bind loop_addr_gen loop_addr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .tick      (tick),
  .run       (run),
  .pos_rd    (pos_rd),
  .end_pulse (end_pulse),
  .adv_go    (adv_go),
  .adv_ovf   (adv_ovf),
  .wrap_evt  (wrap_evt),
  .halt_q    (halt_q)
);

// File: tb/test_loop_addr_gen.sv
module test_loop_addr_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        tick, run;
  logic [31:0] fetch_addr, pos_rd;
  logic        end_pulse;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // reference model state
  longint m_base, m_last, m_step, m_idx, m_frac;
  bit m_stereo, m_wide, m_loop, m_halt, m_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_addr_gen i_loop_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .run(run), .fetch_addr(fetch_addr), .pos_rd(pos_rd), .end_pulse(end_pulse)
  );

  function automatic longint exp_addr();
    longint bytes;
    bytes = 1;
    if (m_stereo) bytes = bytes * 2;
    if (m_wide)   bytes = bytes * 2;
    return (m_base + m_idx * bytes) % 64'h1_0000_0000;
  endfunction

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("fetch_addr", fetch_addr, exp_addr());
    check("pos_rd", pos_rd, m_idx * 65536 + m_frac);
    check("end_pulse", end_pulse, m_end);
  endtask

  task automatic model_edge(bit w, logic [1:0] s, logic [31:0] d, bit t, bit r);
    longint sum, ni;
    m_end = 0;
    if (w) begin
      case (s)
        2'd0: m_base = d;
        2'd1: begin m_last = d[31:16]; m_step = d[15:0]; end
        2'd2: begin m_idx = d[31:16]; m_frac = d[11:0]; m_halt = 0; end
        default: begin m_stereo = d[14]; m_wide = d[13]; m_loop = d[12]; m_halt = 0; end
      endcase
    end else if (t && r && !m_halt) begin
      sum = m_idx * 4096 + m_frac + m_step;
      ni  = sum / 4096;
      if (ni > m_last) begin
        m_end = 1;
        if (m_loop) begin m_idx = 0; m_frac = sum % 4096; end
        else m_halt = 1;
      end else begin
        m_idx = ni; m_frac = sum % 4096;
      end
    end
  endtask

  // drive one cycle at the falling edge, update the model at the rising edge, compare at the next falling edge
  task automatic cyc(bit w, logic [1:0] s, logic [31:0] d, bit t, bit r);
    wr_en = w; wr_sel = s; wr_data = d; tick = t; run = r;
    @(posedge clk);
    model_edge(w, s, d, t, r);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    cyc(1'b1, s, d, 1'b0, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_base = 0; m_last = 0; m_step = 0; m_idx = 0; m_frac = 0;
    m_stereo = 0; m_wide = 0; m_loop = 0; m_halt = 0; m_end = 0;
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; tick = 0; run = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2 R4 R5 R6: unit step, 8-bit mono, loop over 8 frames
    tag = "R6";
    wr(2'd0, 32'h0000_1000);
    wr(2'd1, {16'd7, 16'd4096});
    wr(2'd3, 32'h0000_1000);
    ticks(20);

    // R2 R4: 44.1 kHz step, 16-bit stereo, loop
    tag = "R2";
    wr(2'd1, {16'd3, 16'd3763});
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0000_F000);
    ticks(12);

    // R4: 16-bit mono and 8-bit stereo frame sizes
    tag = "R4";
    wr(2'd3, 32'h0000_B000);
    wr(2'd1, {16'd100, 16'd4096});
    ticks(5);
    wr(2'd3, 32'h0000_5000);
    ticks(5);

    // R3: tick without run and run without tick do not advance
    tag = "R3";
    for (int i = 0; i < 4; i++) cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b0, 2'd0, 32'd0, 1'b0, 1'b1);

    // R7: no loop, freeze at end; ticks ignored until a release write
    tag = "R7";
    wr(2'd1, {16'd2, 16'd6000});
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0000_0000);
    ticks(8);
    wr(2'd3, 32'h0000_0000);
    ticks(3);
    wr(2'd2, {16'd1, 16'h0123});
    ticks(3);

    // R8: position load with fraction, then clear by writing 0
    tag = "R8";
    wr(2'd1, {16'd500, 16'd2048});
    wr(2'd2, {16'd300, 4'hF, 12'hABC});
    ticks(3);
    wr(2'd2, 32'h0);
    ticks(2);

    // R9: writes take priority over a coincident tick
    tag = "R9";
    cyc(1'b1, 2'd2, {16'd40, 16'd0}, 1'b1, 1'b1);
    cyc(1'b1, 2'd0, 32'h0000_8000, 1'b1, 1'b1);
    ticks(2);

    // R5: step above one frame with a short looping buffer
    tag = "R5";
    wr(2'd3, 32'h0000_1000);
    wr(2'd1, {16'd0, 16'd5000});
    wr(2'd2, 32'h0);
    ticks(6);
    wr(2'd1, {16'd9, 16'd1365});
    for (int i = 0; i < 120; i++) cyc(1'b0, 2'd0, 32'd0, (i % 3) != 1, (i % 7) != 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule